// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block moves bytes over a four-wire synchronous serial link: a clock, a data line toward the peripheral, a data line back from it, and an active-low select. A single shift register serves both directions at once, so every byte sent is traded for a byte received. A control bit picks the role. As bus master, the block divides the system clock to make the serial clock and drives the select low for the length of one byte. As bus slave, it follows a serial clock and select that another device supplies, after passing them through synchronizers.

A host uses three registers through a small read/write port. A host write to the data register while idle in master mode starts a byte. When the byte ends, a done flag rises and the received byte appears in the data register. If the host writes the data register while a byte is still moving, the write is dropped and a collision flag rises. Both flags clear when the host reads the status register and then touches the data register. The serial clock rests low. Each bit is sampled on the rising clock edge, and the outgoing line changes on the falling edge.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, the select output is 1, the serial clock output is 0, and both the status register (address 1) and the data register (address 2) read 0.
- R2: In master mode, with control bit 0 (enable) = 1 and bit 1 (master) = 1, a host write to address 2 while idle starts a byte. The select output then stays low for exactly 8 rising edges of the serial clock and returns high. The clock rests at 0 whenever no byte is in flight.
- R3: During a master byte, the outgoing data line carries the written byte, sampled at each rising clock edge. At the end, address 2 reads the byte taken from the incoming data line.
- R4: Control bit 2 selects bit order: 1 sends and receives the least significant bit first, 0 sends and receives the most significant bit first.
- R5: Control bits 4:3 select a serial clock period of 4, 16, 64 or 128 system clocks for codes 0 to 3. Control bit 5 set halves that period, to 2, 8, 32 or 64.
- R6: Status bit 0 (done) goes to 1 when all 8 bits of a byte have been exchanged.
- R7: A write to address 2 while a byte is in flight sets status bit 1 (collision). The write does not change the byte being shifted out or the byte received.
- R8: A flag that is set when the host reads address 1 is cleared by the next read or write of address 2.
- R9: In slave mode (bit 0 = 1, bit 1 = 0), the block shifts on the external serial clock while the external select is low. It presents the byte last written to address 2 on its outgoing line, captures the incoming line into address 2, and sets done after 8 bits.
- R10: If the external select rises before 8 bits are done, the partial byte is dropped: done is not set, and the next byte starts over from the first bit of the byte loaded for sending.
- R11: With control bit 0 = 0, a write to address 2 starts no transfer: the select stays high and the status register stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (used for the flag-clear sequence) |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for host_addr, combinational |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Outgoing data in master mode |
| ss_n_out | output | 1 | Select driven in master mode, active low |
| miso_in | input | 1 | Incoming data in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| mosi_in | input | 1 | Incoming data in slave mode |
| ss_n_in | input | 1 | Select received in slave mode, active low |
| miso_out | output | 1 | Outgoing data in slave mode |

## Verification
The bench measures the interval between serial clock rising edges at the fastest setting (divide by 2) and the slowest (divide by 128), so a divider off by one half period shows up as a wrong interval. It rebuilds the byte seen on the outgoing line with a bench slave model in both bit orders, so swapped bit order or a missing bit shows up as a wrong byte. A write made in the middle of a slow byte must raise the collision flag and leave both bytes intact. A design that latches the late write would put a different byte on the line. In slave mode, a select released after three bits must leave done low, and the following full byte must start again from its first bit. A design that kept the bit count across the release would finish early and return a shifted byte.

// File: rtl/spi_xcvr_pkg.sv
`timescale 1ns/1ps
package spi_xcvr_pkg;
   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_STAT = 2'd1,
      A_DATA = 2'd2,
      A_RSVD = 2'd3
   } reg_addr_e;

   localparam int B_EN   = 0;
   localparam int B_MST  = 1;
   localparam int B_LSB  = 2;
   localparam int B_RATE = 3;
   localparam int B_DBL  = 5;
   localparam int CTRL_BITS = 6;
endpackage

// File: rtl/spi_xcvr_sync.sv
`timescale 1ns/1ps
module spi_xcvr_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_chk_stages
      $error("spi_xcvr_sync: STAGES must be 2 or more");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_xcvr_clkgen.sv
`timescale 1ns/1ps
module spi_xcvr_clkgen #(
   parameter int MAX_DIV = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate_sel,
   input  logic       dbl,
   output logic       sck,
   output logic       rise_p,
   output logic       fall_p
);
   localparam int CNT_W = $clog2(MAX_DIV / 2);

   if (MAX_DIV < 128) begin : g_chk_div
      $error("spi_xcvr_clkgen: MAX_DIV must cover divide by 128");
   end

   logic [2:0]       div_log;
   logic [2:0]       half_log;
   logic [CNT_W-1:0] half_m1;
   logic [CNT_W-1:0] cnt;
   logic             tick;

   always_comb begin
      unique case (rate_sel)
         2'd0:    div_log = 3'd2;
         2'd1:    div_log = 3'd4;
         2'd2:    div_log = 3'd6;
         default: div_log = 3'd7;
      endcase
      half_log = div_log - {2'b00, dbl} - 3'd1;
      half_m1  = CNT_W'((32'd1 << half_log) - 32'd1);
   end

   assign tick   = run && (cnt == half_m1);
   assign rise_p = tick && !sck;
   assign fall_p = tick && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_toggle_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $past(run));
endmodule

// File: rtl/spi_xcvr_shift.sv
`timescale 1ns/1ps
module spi_xcvr_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         sample_p,
   input  logic         shift_p,
   input  logic         in_bit,
   input  logic         lsb_first,
   output logic         out_bit,
   output logic [W-1:0] sr_q,
   output logic [W-1:0] nxt,
   output logic         done_p,
   output logic [$clog2(W)-1:0] bit_cnt
);
   localparam int CW = $clog2(W);

   if (W < 2) begin : g_chk_w
      $error("spi_xcvr_shift: W must be 2 or more");
   end

   logic samp;

   assign nxt     = lsb_first ? {samp, sr_q[W-1:1]} : {sr_q[W-2:0], samp};
   assign out_bit = lsb_first ? sr_q[0] : sr_q[W-1];
   assign done_p  = shift_p && (bit_cnt == CW'(W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         bit_cnt <= '0;
         samp    <= 1'b0;
      end else begin
         if (sample_p) samp <= in_bit;
         if (load) begin
            sr_q    <= load_val;
            bit_cnt <= '0;
         end else if (shift_p) begin
            sr_q    <= nxt;
            bit_cnt <= done_p ? '0 : bit_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_xcvr.sv
`timescale 1ns/1ps
module spi_xcvr
   import spi_xcvr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int MAX_DIV     = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              sck_out,
   output logic              mosi_out,
   output logic              ss_n_out,
   input  logic              miso_in,
   input  logic              sck_in,
   input  logic              mosi_in,
   input  logic              ss_n_in,
   output logic              miso_out
);
   localparam int CW = $clog2(DATA_W);

   if (DATA_W < CTRL_BITS + 2) begin : g_chk_w
      $error("spi_xcvr: DATA_W too narrow for control register");
   end

   logic [DATA_W-1:0] ctrl_q, tx_hold, rx_buf, sr_q, nxt, load_val;
   logic [CW-1:0]     bit_cnt;
   logic [1:0]        arm;
   logic              m_busy, st_done, st_wcol;
   logic              sck_s, ss_s, mosi_s, sck_d;
   logic              sck_g, rise_p, fall_p;
   logic              load, sample_p, shift_p, in_bit, out_bit, done_p;

   wire en       = ctrl_q[B_EN];
   wire is_mst   = ctrl_q[B_MST];
   wire lsb      = ctrl_q[B_LSB];
   wire dbl      = ctrl_q[B_DBL];
   wire [1:0] rs = ctrl_q[B_RATE+1:B_RATE];

   wire wr_ctrl  = host_wr && (host_addr == A_CTRL);
   wire wr_data  = host_wr && (host_addr == A_DATA);
   wire rd_stat  = host_rd && (host_addr == A_STAT);
   wire acc_data = (host_wr || host_rd) && (host_addr == A_DATA);

   wire slv_mode = en && !is_mst;
   wire slv_sel  = slv_mode && !ss_s;
   wire in_xfer  = m_busy || slv_sel;
   wire start    = wr_data && en && is_mst && !m_busy;
   wire coll     = wr_data && in_xfer;
   wire s_rise   = slv_sel && sck_s && !sck_d;
   wire s_fall   = slv_sel && !sck_s && sck_d;

   spi_xcvr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sck_in, ss_n_in, mosi_in}),
      .q({sck_s, ss_s, mosi_s})
   );

   spi_xcvr_clkgen #(.MAX_DIV(MAX_DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(m_busy), .rate_sel(rs), .dbl(dbl),
      .sck(sck_g), .rise_p(rise_p), .fall_p(fall_p)
   );

   assign load     = start || (slv_mode && ss_s);
   assign load_val = start ? host_wdata : tx_hold;
   assign sample_p = m_busy ? rise_p : s_rise;
   assign shift_p  = m_busy ? fall_p : s_fall;
   assign in_bit   = m_busy ? miso_in : mosi_s;

   spi_xcvr_shift #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .sample_p(sample_p), .shift_p(shift_p), .in_bit(in_bit), .lsb_first(lsb),
      .out_bit(out_bit), .sr_q(sr_q), .nxt(nxt), .done_p(done_p), .bit_cnt(bit_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         tx_hold <= '0;
         rx_buf  <= '0;
         m_busy  <= 1'b0;
         st_done <= 1'b0;
         st_wcol <= 1'b0;
         arm     <= 2'b00;
         sck_d   <= 1'b0;
      end else begin
         sck_d <= sck_s;
         if (wr_ctrl) ctrl_q <= host_wdata;
         if (wr_data && !in_xfer) tx_hold <= host_wdata;
         if (done_p) rx_buf <= nxt;

         if (!en)                  m_busy <= 1'b0;
         else if (start)           m_busy <= 1'b1;
         else if (m_busy && done_p) m_busy <= 1'b0;

         if (rd_stat)       arm <= {st_wcol, st_done};
         else if (acc_data) arm <= 2'b00;

         if (done_p)                 st_done <= 1'b1;
         else if (acc_data && arm[0]) st_done <= 1'b0;

         if (coll)                   st_wcol <= 1'b1;
         else if (acc_data && arm[1]) st_wcol <= 1'b0;
      end
   end

   always_comb begin
      unique case (host_addr)
         A_CTRL:  host_rdata = ctrl_q;
         A_STAT:  host_rdata = {{(DATA_W-2){1'b0}}, st_wcol, st_done};
         A_DATA:  host_rdata = rx_buf;
         default: host_rdata = '0;
      endcase
   end

   assign sck_out  = sck_g;
   assign mosi_out = out_bit;
   assign miso_out = out_bit;
   assign ss_n_out = !m_busy;

   assert_sck_rests_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !m_busy |=> !sck_out);
   assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |=> st_done);
   assert_wcol_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_busy && wr_data) |=> st_wcol);
   assert_wcol_no_corrupt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_busy && wr_data && !shift_p) |=> (sr_q == $past(sr_q)));
   assert_abort_resets_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_mode && ss_s) |=> (bit_cnt == '0));
endmodule

// File: tb/spi_xcvr_bench.sv
`timescale 1ns/1ps
module spi_xcvr_bench;
   localparam int HP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       sck_out, mosi_out, ss_n_out, miso_out;
   logic       miso_in = 1'b0, sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   spi_xcvr u_spi_xcvr (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sck_out(sck_out), .mosi_out(mosi_out), .ss_n_out(ss_n_out), .miso_in(miso_in),
      .sck_in(sck_in), .mosi_in(mosi_in), .ss_n_in(ss_n_in), .miso_out(miso_out)
   );

   function automatic int divf(input logic [1:0] rs, input logic db);
      int d;
      case (rs)
         2'd0: d = 4;
         2'd1: d = 16;
         2'd2: d = 64;
         default: d = 128;
      endcase
      return db ? d / 2 : d;
   endfunction

   function automatic logic sb(input logic [7:0] b, input int k, input logic lsb);
      return lsb ? b[k] : b[7-k];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   // bench slave model and serial clock monitor for master mode
   realtime    last_rise;
   int         n_rise = 0, per_bad = 0, exp_div = 4, mk = 0;
   logic [7:0] cap = 8'h00, mdl_tx = 8'h00;
   logic       mdl_lsb = 1'b0;

   always @(posedge sck_out) begin
      int idx;
      if (n_rise > 0 && ($realtime - last_rise) != exp_div * 4.0) per_bad++;
      last_rise = $realtime;
      if (n_rise < 8) begin
         idx = mdl_lsb ? n_rise : 7 - n_rise;
         cap[idx] = mosi_out;
      end
      n_rise++;
   end

   always @(negedge ss_n_out) begin
      mk = 0;
      miso_in = sb(mdl_tx, 0, mdl_lsb);
   end

   always @(negedge sck_out) begin
      mk++;
      if (mk < 8) miso_in = sb(mdl_tx, mk, mdl_lsb);
   end

   task automatic mxfer(input logic [7:0] tx, input logic [7:0] stx, input logic [1:0] rs,
                        input logic db, input logic lsb, input bit coll);
      logic [7:0] d;
      int w;
      wr(2'd0, {2'b00, db, rs, lsb, 2'b11});
      mdl_tx = stx; mdl_lsb = lsb; exp_div = divf(rs, db);
      n_rise = 0; per_bad = 0; cap = 8'h00;
      wr(2'd2, tx);
      chk(ss_n_out == 1'b0, "R2 select low after start", ss_n_out, 0);
      if (coll) begin
         repeat (3 * exp_div) @(negedge clk);
         wr(2'd2, ~tx);
         rd(2'd1, d);
         chk(d == 8'h02, "R7 collision flag mid byte", d, 8'h02);
      end
      w = 0;
      while (ss_n_out !== 1'b1 && w < 4000) begin
         @(negedge clk);
         w++;
      end
      repeat (2) @(negedge clk);
      chk(n_rise == 8, "R2 eight clock edges", n_rise, 8);
      chk(per_bad == 0, "R5 clock period", per_bad, 0);
      chk(cap == tx, "R3 outgoing byte (R4 order)", cap, tx);
      rd(2'd1, d);
      chk(d == (coll ? 8'h03 : 8'h01), "R6 done flag", d, coll ? 3 : 1);
      rd(2'd2, d);
      chk(d == stx, "R3 received byte (R4 order)", d, stx);
      rd(2'd1, d);
      chk(d == 8'h00, "R8 flags cleared", d, 0);
   endtask

   task automatic sbit(input logic b);
      mosi_in = b;
      repeat (HP) @(negedge clk);
      sck_in = 1'b1;
      repeat (HP) @(negedge clk);
      sck_in = 1'b0;
   endtask

   task automatic sxfer(input logic [7:0] load, input logic [7:0] mtx, input logic lsb,
                        input int abort_bits);
      logic [7:0] d;
      int mm;
      sck_in = 1'b0; ss_n_in = 1'b1;
      wr(2'd0, {5'b00000, lsb, 2'b01});
      wr(2'd2, load);
      repeat (6) @(negedge clk);
      if (abort_bits > 0) begin
         ss_n_in = 1'b0;
         repeat (HP) @(negedge clk);
         for (int k = 0; k < abort_bits; k++) sbit(1'($urandom & 1));
         repeat (HP) @(negedge clk);
         ss_n_in = 1'b1;
         repeat (6) @(negedge clk);
         rd(2'd1, d);
         chk(d == 8'h00, "R10 no done after early release", d, 0);
      end
      ss_n_in = 1'b0;
      repeat (HP) @(negedge clk);
      mm = 0;
      for (int k = 0; k < 8; k++) begin
         mosi_in = sb(mtx, k, lsb);
         repeat (HP) @(negedge clk);
         if (miso_out !== sb(load, k, lsb)) mm++;
         sck_in = 1'b1;
         repeat (HP) @(negedge clk);
         sck_in = 1'b0;
      end
      repeat (HP) @(negedge clk);
      ss_n_in = 1'b1;
      repeat (6) @(negedge clk);
      chk(mm == 0, abort_bits > 0 ? "R10 restart from first bit" : "R9 outgoing bits", mm, 0);
      rd(2'd1, d);
      chk(d == 8'h01, "R9 done in slave mode", d, 1);
      rd(2'd2, d);
      chk(d == mtx, abort_bits > 0 ? "R10 byte after release" : "R9 received byte", d, mtx);
      rd(2'd1, d);
      chk(d == 8'h00, "R8 flags cleared in slave mode", d, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int seed;
      seed = $urandom(32'd20240);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ss_n_out == 1'b1, "R1 select idle", ss_n_out, 1);
      chk(sck_out == 1'b0, "R1 clock idle", sck_out, 0);
      rd(2'd1, d);
      chk(d == 8'h00, "R1 status", d, 0);
      rd(2'd2, d);
      chk(d == 8'h00, "R1 data", d, 0);

      // R11 disabled block ignores data write
      wr(2'd0, 8'h02);
      wr(2'd2, 8'h5A);
      repeat (20) @(negedge clk);
      chk(ss_n_out == 1'b1, "R11 no start when disabled", ss_n_out, 1);
      rd(2'd1, d);
      chk(d == 8'h00, "R11 status unchanged", d, 0);

      // directed master corners: fastest, slowest, collision
      mxfer(8'hA5, 8'h3C, 2'd0, 1'b1, 1'b0, 1'b0);
      mxfer(8'h81, 8'h7E, 2'd3, 1'b0, 1'b1, 1'b0);
      mxfer(8'h5A, 8'hC3, 2'd3, 1'b0, 1'b0, 1'b1);
      mxfer(8'h0F, 8'hF0, 2'd2, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 16; i++)
         mxfer(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom & 1),
               1'($urandom & 1), 1'b0);

      // slave mode
      sxfer(8'h96, 8'h4B, 1'b0, 0);
      sxfer(8'h1E, 8'hE1, 1'b1, 3);
      for (int i = 0; i < 6; i++)
         sxfer(8'($urandom), 8'($urandom), 1'($urandom & 1), (i % 2 == 0) ? 0 : 1 + i);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule